// File: doc/BRIEF.md
# Switchable-Width Memory Data Gearbox

This block sits between a 64-bit memory-controller data port and the external data lines. It runs in one of two modes. In wide mode every lane has its own line. In narrow mode only 16 dedicated lines carry traffic, and each word goes over them in four beats. The other 48 lines are released for other use.

In narrow mode each dedicated line carries a group of four adjacent lanes, one lane per beat. Transmit loads a whole word and shifts it out beat by beat. Receive collects the beats and hands the controller one reassembled word.

The wide path goes through a registered delay line. Its depth is set so that a word takes exactly as many clock edges in wide mode as the last beat of a narrow word. Both directions use valid/ready handshakes on the controller side and on the line side. A mode request only takes effect once no word is partly transferred in either direction.

Top module: `width_gearbox`

## Requirements
- R1: After reset the block is in wide mode, with `lineOutValid` and `rxValid` low and every bit of `lineOe` high (1 means the line is driven).
- R2: In wide mode a transmit word is accepted in every cycle with `lineOutReady` high and no mode change pending. Each accepted word appears unchanged on all 64 bits of `lineOut`, in the order the words were accepted.
- R3: In narrow mode an accepted word leaves as four consecutive beats, k = 0..3. In beat k, line j (j = 0..15) carries lane 4j+k, so beat 0 has the lowest lane of each group.
- R4: In narrow mode `lineOe` is high only on the dedicated lines 0..15. Lines 16..63 of `lineOut` are driven to zero.
- R5: In wide mode each word taken from `lineIn` is delivered unchanged on `rxData`, in order.
- R6: In narrow mode four taken beats are reassembled into one word: bit 4j+k of the word comes from line j of beat k. `lineIn` bits 16..63 have no effect on the delivered word.
- R7: While `lineOutReady` is low, a valid `lineOut` beat is held unchanged. While `rxReady` is low, a valid `rxData` word is held unchanged.
- R8: A mode change (`narrowReq` 1 = narrow, 0 = wide) takes effect only when no word is partly shifted or in flight. While the change is pending, `txReady` stays low, and `lineInReady` stays low unless a narrow receive word is partly collected.
- R9: In narrow mode `txReady` is low until the last beat of the word in progress is being handed to the lines, so at most one word is accepted per four beats.
- R10: With no stalls, the last lane of a word is presented exactly 4 cycles after its acceptance cycle in both modes and in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory interface clock |
| rstN | input | 1 | Active-low synchronous reset |
| narrowReq | input | 1 | Requested mode: 1 narrow, 0 wide |
| txValid | input | 1 | Controller transmit word valid |
| txReady | output | 1 | Block accepts the transmit word |
| txData | input | 64 | Controller transmit word |
| lineOut | output | 64 | Data driven towards the lines |
| lineOe | output | 64 | Per-line drive enable |
| lineOutValid | output | 1 | `lineOut` holds a beat or word |
| lineOutReady | input | 1 | Line side takes the beat or word |
| lineIn | input | 64 | Data received from the lines |
| lineInValid | input | 1 | `lineIn` holds a beat or word |
| lineInReady | output | 1 | Block takes the received beat or word |
| rxData | output | 64 | Reassembled receive word |
| rxValid | output | 1 | `rxData` valid |
| rxReady | input | 1 | Controller takes the receive word |

## Verification
The assertions assume that `rstN` is held low for at least one clock edge before traffic starts. They also assume the line side holds a valid beat steady until it is taken. The bench keeps within these assumptions: it changes inputs only at falling edges and counts a transfer only when valid and ready are both high. It flips `narrowReq` at random moments, including in the middle of a narrow word, so that the deferral logic is exercised. The latency checks are enabled only in phases where both ready inputs and `lineInValid` are held high throughout.

// File: rtl/gear_pkg.sv
package gear_pkg;
  // Strobes from the control to the datapath, one set per clock cycle.
  typedef struct packed {
    logic txAdv;   // transmit side advances (line side ready)
    logic txLoad;  // a controller word is accepted this cycle
    logic rxAdv;   // receive side advances (controller ready)
    logic rxTake;  // a line beat or word is taken this cycle
    logic rxLast;  // the taken narrow beat completes a word
    logic narrow;  // current mode
  } gearStb_t;
endpackage

// File: rtl/gear_ctrl.sv
module gear_ctrl import gear_pkg::*; #(
  parameter int BEATS = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     narrowReq,
  input  logic     txValid,
  input  logic     lineOutReady,
  input  logic     lineInValid,
  input  logic     rxReady,
  output logic     txReady,
  output logic     lineInReady,
  output logic     lineOutValid,
  output logic     rxValid,
  output logic     narrowMode,
  output gearStb_t stb
);
  localparam int STG   = BEATS - 1;
  localparam int CNT_W = (BEATS > 2) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

  logic             narrowQ;
  logic [CNT_W-1:0] txCnt, rxCnt;
  logic [STG-1:0]   txPipeV, rxPipeV;
  logic             txOutV, rxOutV;
  logic             pending, canSwitch;
  logic             txAdv, rxAdv, txLoad, rxTake, rxLast;

  assign txAdv   = lineOutReady;
  assign rxAdv   = rxReady;
  assign pending = (narrowReq != narrowQ);

  assign txReady     = txAdv && !pending && (!narrowQ || (txCnt == '0));
  assign txLoad      = txValid && txReady;
  assign lineInReady = rxAdv && !(pending && (rxCnt == '0));
  assign rxTake      = lineInValid && lineInReady;
  assign rxLast      = narrowQ && (rxCnt == LAST_BEAT);

  assign canSwitch = pending && (txCnt == '0) && (rxCnt == '0) &&
                     (txPipeV == '0) && (rxPipeV == '0) &&
                     (!txOutV || txAdv) && (!rxOutV || rxAdv);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      narrowQ <= 1'b0;
      txCnt   <= '0;
      rxCnt   <= '0;
      txPipeV <= '0;
      rxPipeV <= '0;
      txOutV  <= 1'b0;
      rxOutV  <= 1'b0;
    end else begin
      if (canSwitch) narrowQ <= narrowReq;
      if (txAdv) begin
        txPipeV <= (txPipeV << 1) | STG'(txLoad && !narrowQ);
        txOutV  <= narrowQ ? (txLoad || (txCnt != '0)) : txPipeV[STG-1];
        if (txLoad && narrowQ)  txCnt <= LAST_BEAT;
        else if (txCnt != '0)   txCnt <= txCnt - CNT_W'(1);
      end
      if (rxAdv) begin
        rxPipeV <= (rxPipeV << 1) | STG'(rxTake && !narrowQ);
        rxOutV  <= narrowQ ? (rxTake && rxLast) : rxPipeV[STG-1];
      end
      if (rxTake && narrowQ) rxCnt <= rxLast ? '0 : rxCnt + CNT_W'(1);
    end
  end

  assign lineOutValid = txOutV;
  assign rxValid      = rxOutV;
  assign narrowMode   = narrowQ;
  assign stb = '{txAdv: txAdv, txLoad: txLoad, rxAdv: rxAdv,
                 rxTake: rxTake, rxLast: rxLast, narrow: narrowQ};

  // R8: the mode only flips on a word boundary
  p_mode_boundary_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(narrowQ) |-> $past((txCnt == '0) && (rxCnt == '0)));
  // R8: no new transmit word while a change waits
  p_pending_block_r8: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> !txReady);
  // R9: no new word while narrow beats remain
  p_busy_block_r9: assert property (@(posedge clk) disable iff (!rstN)
    (narrowQ && (txCnt != '0)) |-> !txReady);
  // R3: narrow beats follow one another without gaps
  p_beat_run_r3: assert property (@(posedge clk) disable iff (!rstN)
    (narrowQ && (txCnt != '0) && txAdv) |=> lineOutValid);
endmodule

// File: rtl/gear_path.sv
module gear_path import gear_pkg::*; #(
  parameter int WORD_W = 64,
  parameter int BEATS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  gearStb_t          stb,
  input  logic [WORD_W-1:0] txData,
  input  logic [WORD_W-1:0] lineIn,
  output logic [WORD_W-1:0] lineOut,
  output logic [WORD_W-1:0] rxData
);
  localparam int LINE_N = WORD_W / BEATS;
  localparam int STG    = BEATS - 1;

  logic [WORD_W-1:0] txStg [STG];
  logic [WORD_W-1:0] rxStg [STG];
  logic [WORD_W-1:0] txShift, rxCol, rxNext, outQ, rxQ;
  logic [LINE_N-1:0] beatNew, beatCont;

  // Lane 4j+k sits at bit 4j after k single-bit right shifts of the word.
  for (genvar j = 0; j < LINE_N; j++) begin : g_beat
    assign beatNew[j]  = txData[j*BEATS];
    assign beatCont[j] = txShift[j*BEATS];
  end

  // Receive: each beat enters at the top of its group and moves down.
  always_comb begin
    rxNext = rxCol >> 1;
    for (int j = 0; j < LINE_N; j++) rxNext[j*BEATS + BEATS - 1] = lineIn[j];
  end

  // Matching delay lines for the wide bypass.
  for (genvar k = 0; k < STG; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        txStg[k] <= '0;
        rxStg[k] <= '0;
      end else begin
        if (stb.txAdv) txStg[k] <= (k == 0) ? txData : txStg[(k == 0) ? 0 : k-1];
        if (stb.rxAdv) rxStg[k] <= (k == 0) ? lineIn : rxStg[(k == 0) ? 0 : k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      outQ    <= '0;
      rxCol   <= '0;
      rxQ     <= '0;
    end else begin
      if (stb.txAdv) begin
        txShift <= stb.txLoad ? (txData >> 1) : (txShift >> 1);
        if (stb.narrow)
          outQ <= {{(WORD_W-LINE_N){1'b0}}, (stb.txLoad ? beatNew : beatCont)};
        else
          outQ <= txStg[STG-1];
      end
      if (stb.rxTake && stb.narrow) rxCol <= rxNext;
      if (stb.rxAdv) begin
        if (!stb.narrow)                 rxQ <= rxStg[STG-1];
        else if (stb.rxTake && stb.rxLast) rxQ <= rxNext;
      end
    end
  end

  assign lineOut = outQ;
  assign rxData  = rxQ;

  // R7: line data holds while the line side stalls
  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.txAdv |=> $stable(lineOut));
  // R7: receive word holds while the controller stalls
  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rxAdv |=> $stable(rxData));
endmodule

// File: rtl/width_gearbox.sv
module width_gearbox import gear_pkg::*; #(
  parameter int WORD_W = 64,
  parameter int BEATS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              narrowReq,
  input  logic              txValid,
  output logic              txReady,
  input  logic [WORD_W-1:0] txData,
  output logic [WORD_W-1:0] lineOut,
  output logic [WORD_W-1:0] lineOe,
  output logic              lineOutValid,
  input  logic              lineOutReady,
  input  logic [WORD_W-1:0] lineIn,
  input  logic              lineInValid,
  output logic              lineInReady,
  output logic [WORD_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady
);
  localparam int LINE_N = WORD_W / BEATS;

  gearStb_t stb;
  logic     narrowMode;

  gear_ctrl #(.BEATS(BEATS)) i_ctrl (
    .clk(clk), .rstN(rstN), .narrowReq(narrowReq), .txValid(txValid),
    .lineOutReady(lineOutReady), .lineInValid(lineInValid), .rxReady(rxReady),
    .txReady(txReady), .lineInReady(lineInReady), .lineOutValid(lineOutValid),
    .rxValid(rxValid), .narrowMode(narrowMode), .stb(stb)
  );

  gear_path #(.WORD_W(WORD_W), .BEATS(BEATS)) i_path (
    .clk(clk), .rstN(rstN), .stb(stb), .txData(txData), .lineIn(lineIn),
    .lineOut(lineOut), .rxData(rxData)
  );

  assign lineOe = narrowMode ? {{(WORD_W-LINE_N){1'b0}}, {LINE_N{1'b1}}}
                             : {WORD_W{1'b1}};

  // R4: released lines carry no data in narrow mode
  p_upper_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (narrowMode && lineOutValid) |-> (lineOut[WORD_W-1:LINE_N] == '0));
endmodule

// File: tb/test_width_gearbox.sv
module test_width_gearbox;
  localparam int CLK_P  = 10;
  localparam int WORD_W = 64;
  localparam int BEATS  = 4;
  localparam int LINE_N = WORD_W / BEATS;

  logic clk = 1'b0;
  logic rstN, narrowReq, txValid, txReady, lineOutValid, lineOutReady;
  logic lineInValid, lineInReady, rxValid, rxReady;
  logic [WORD_W-1:0] txData, lineOut, lineOe, lineIn, rxData;

  always #(CLK_P/2) clk = ~clk;

  width_gearbox #(.WORD_W(WORD_W), .BEATS(BEATS)) i_width_gearbox (.*);

  int errs = 0, checks = 0, cyc = 0, txK = 0, rxK = 0, rxStart = 0;
  bit latOn = 0, done = 0;
  logic [WORD_W-1:0] txQ[$], rxQ[$], rxAsm, pOut, pRx;
  int txT[$], rxT[$];
  logic pOutV = 0, pOutR = 0, pRxV = 0, pRxR = 0, pMode = 0;

  task automatic chk(bit ok, string req, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [WORD_W-1:0] beatOf(logic [WORD_W-1:0] w, int k);
    beatOf = '0;
    for (int j = 0; j < LINE_N; j++) beatOf[j] = w[j*BEATS + k];
  endfunction

  function automatic logic [WORD_W-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  // Evaluate the current cycle, then advance one clock.
  task automatic step();
    bit mode;
    #1;
    cyc++;
    mode = (lineOe[WORD_W-1] == 1'b0);
    if (pOutV && !pOutR) chk(lineOutValid && lineOut == pOut, "R7 tx hold", lineOut, pOut);
    if (pRxV && !pRxR)   chk(rxValid && rxData == pRx, "R7 rx hold", rxData, pRx);
    if (mode != pMode)
      chk(txQ.size() == 0 && rxQ.size() == 0 && rxK == 0, "R8 boundary",
          WORD_W'(txQ.size() + rxQ.size() + rxK), '0);
    if (narrowReq != mode) begin
      chk(!txReady, "R8 tx blocked", WORD_W'(txReady), '0);
      if (rxK == 0) chk(!lineInReady, "R8 rx blocked", WORD_W'(lineInReady), '0);
    end
    if (mode && txReady)
      chk(txQ.size() == 0 || (txQ.size() == 1 && txK == BEATS-1 && lineOutValid),
          "R9 one word per four beats", WORD_W'(txQ.size()), '0);
    if (mode) chk(lineOe == {{(WORD_W-LINE_N){1'b0}}, {LINE_N{1'b1}}}, "R4 oe",
                  lineOe, {{(WORD_W-LINE_N){1'b0}}, {LINE_N{1'b1}}});
    else      chk(lineOe == '1, "R2 oe", lineOe, '1);
    // transmit output
    if (lineOutValid && lineOutReady) begin
      if (txQ.size() == 0) chk(0, "R2 spurious line output", lineOut, '0);
      else if (!mode) begin
        chk(lineOut == txQ[0], "R2 wide word", lineOut, txQ[0]);
        if (txT[0] >= 0) chk(cyc - txT[0] == BEATS, "R10 wide tx latency",
                             WORD_W'(cyc - txT[0]), WORD_W'(BEATS));
        void'(txQ.pop_front()); void'(txT.pop_front());
      end else begin
        chk(lineOut == beatOf(txQ[0], txK), "R3 narrow beat", lineOut, beatOf(txQ[0], txK));
        txK++;
        if (txK == BEATS) begin
          if (txT[0] >= 0) chk(cyc - txT[0] == BEATS, "R10 narrow tx latency",
                               WORD_W'(cyc - txT[0]), WORD_W'(BEATS));
          void'(txQ.pop_front()); void'(txT.pop_front());
          txK = 0;
        end
      end
    end
    if (txValid && txReady) begin
      txQ.push_back(txData);
      txT.push_back(latOn ? cyc : -1);
    end
    // receive output
    if (rxValid && rxReady) begin
      if (rxQ.size() == 0) chk(0, "R5 spurious rx word", rxData, '0);
      else begin
        chk(rxData == rxQ[0], mode ? "R6 narrow rx word" : "R5 wide rx word", rxData, rxQ[0]);
        if (rxT[0] >= 0) chk(cyc - rxT[0] == BEATS, "R10 rx latency",
                             WORD_W'(cyc - rxT[0]), WORD_W'(BEATS));
        void'(rxQ.pop_front()); void'(rxT.pop_front());
      end
    end
    if (lineInValid && lineInReady) begin
      if (!mode) begin
        rxQ.push_back(lineIn);
        rxT.push_back(latOn ? cyc : -1);
      end else begin
        if (rxK == 0) begin rxStart = latOn ? cyc : -1; rxAsm = '0; end
        for (int j = 0; j < LINE_N; j++) rxAsm[j*BEATS + rxK] = lineIn[j];
        rxK++;
        if (rxK == BEATS) begin
          rxQ.push_back(rxAsm);
          rxT.push_back(rxStart);
          rxK = 0;
        end
      end
    end
    pOut = lineOut; pOutV = lineOutValid; pOutR = lineOutReady;
    pRx = rxData; pRxV = rxValid; pRxR = rxReady; pMode = mode;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 30; i++) begin
      txValid = 0; lineInValid = (rxK != 0); lineIn = rnd64();
      lineOutReady = 1; rxReady = 1;
      step();
    end
  endtask

  task automatic goMode(bit nm);
    narrowReq = nm;
    for (int i = 0; i < 30 && (lineOe[WORD_W-1] == nm); i++) begin
      txValid = 0; lineInValid = (rxK != 0); lineOutReady = 1; rxReady = 1;
      step();
    end
    chk(lineOe[WORD_W-1] == !nm, "R8 mode reached", lineOe, {WORD_W{!nm}});
  endtask

  task automatic streamFull(int n);
    latOn = 1;
    for (int i = 0; i < n; i++) begin
      txValid = 1; txData = rnd64(); lineInValid = 1; lineIn = rnd64();
      lineOutReady = 1; rxReady = 1;
      step();
    end
    drain();
    latOn = 0;
  endtask

  task automatic randomRun(int n, int flipPct);
    for (int i = 0; i < n; i++) begin
      if (($urandom % 100) < flipPct) narrowReq = ~narrowReq;
      txValid = ($urandom % 4) != 0; txData = rnd64();
      lineInValid = ($urandom % 4) != 0; lineIn = rnd64();
      lineOutReady = ($urandom % 5) != 0; rxReady = ($urandom % 5) != 0;
      step();
    end
  endtask

  initial begin
    void'($urandom(32'h1d5a_7c03));
    rstN = 0; narrowReq = 0; txValid = 0; txData = '0; lineIn = '0;
    lineInValid = 0; lineOutReady = 1; rxReady = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    // R1: reset state
    chk(!lineOutValid && !rxValid, "R1 valids low", {lineOutValid, rxValid}, '0);
    chk(lineOe == '1, "R1 all lines driven", lineOe, '1);
    chk(txReady && lineInReady, "R1 ready in wide", {txReady, lineInReady}, 2'b11);

    // Wide mode, back-to-back with no stalls: R2, R5, R10
    streamFull(20);
    randomRun(300, 0);
    drain();

    // Narrow mode: R3, R4, R6, R9, R10
    goMode(1);
    streamFull(40);
    randomRun(600, 0);
    drain();

    // Directed R8: request wide in the middle of a narrow word in both directions
    txValid = 1; txData = 64'h0123_4567_89ab_cdef; lineInValid = 1; lineIn = rnd64();
    lineOutReady = 1; rxReady = 1;
    step();
    txValid = 0; narrowReq = 0; lineIn = rnd64();
    step();
    chk(lineOe[WORD_W-1] == 1'b0, "R8 change held mid-word", lineOe, '0);
    lineIn = rnd64();
    step();
    chk(lineOe[WORD_W-1] == 1'b0, "R8 change still held", lineOe, '0);
    goMode(0);
    drain();

    // Directed R7: long stall on both sides with a word in flight
    txValid = 1; txData = rnd64(); lineInValid = 1; lineIn = rnd64();
    lineOutReady = 1; rxReady = 1;
    step();
    txValid = 0; lineInValid = 0;
    step(); step();
    lineOutReady = 0; rxReady = 0;
    for (int i = 0; i < 6; i++) step();
    drain();

    // Mixed traffic with random mode requests
    randomRun(2000, 2);
    narrowReq = 0;
    drain();
    goMode(0);
    drain();
    chk(txQ.size() == 0 && rxQ.size() == 0, "R2 all words delivered",
        WORD_W'(txQ.size() + rxQ.size()), '0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule